// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block is the byte-merge datapath behind misaligned word accesses. A misaligned word spans two aligned memory words. It is read or written with two partial operations, one for the upper part and one for the lower part. For each partial operation the block takes four inputs: the aligned memory word that holds the addressed byte, the byte offset from the low address bits, the current register value and an operation code. From these it produces the merged register value for loads, or the merged memory word plus a byte-enable mask for stores.

The block is purely combinational and uses one fixed byte order. Byte lane k is bits [8k+7:8k], and offset 0 selects lane 0. The surrounding pipeline supplies the aligned word and commits the results. Address generation and the memory port are outside the block.

Top module: `ua_merge_top`

## Requirements
- R1: `op_i` selects the operation: 0 = load-high, 1 = load-low, 2 = store-high, 3 = store-low.
- R2: Load-high with offset o (N = 4 lanes): output lane k holds memory lane k-(N-1-o) when k >= N-1-o, and register lane k otherwise.
- R3: Load-low with offset o: output lane k holds memory lane k+o when k <= N-1-o, and register lane k otherwise.
- R4: Store-high with offset o: store lane k holds register lane k+(N-1-o) and its byte-enable bit is 1 when k <= o. Otherwise the lane holds memory lane k and the bit is 0.
- R5: Store-low with offset o: store lane k holds register lane k-o and its byte-enable bit is 1 when k >= o. Otherwise the lane holds memory lane k and the bit is 0.
- R6: A full-word merge replaces the whole word. Load-high at offset 3 and load-low at offset 0 return the memory word unchanged. Store-high at offset 3 and store-low at offset 0 return the register word with all four enable bits set.
- R7: During a store, `load_data_o` equals `reg_word_i`. During a load, `store_data_o` equals `mem_word_i` and `byte_en_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 2 | Operation code (see R1) |
| offset_i | input | 2 | Byte offset within the aligned word |
| mem_word_i | input | 32 | Aligned memory word containing the addressed byte |
| reg_word_i | input | 32 | Current register value |
| load_data_o | output | 32 | Merged register value |
| store_data_o | output | 32 | Merged memory word |
| byte_en_o | output | 4 | Byte lanes written by a store |

## Verification
The load merge and the store merge both run on every input set, so in every cycle both paths present a result, and the operation code decides which one is real. The bench sweeps all four operations over all four offsets and several data pairs. For each case it judges all three outputs together. The selected path must match the shift-and-mask formula, computed in 64-bit arithmetic so that full-width shifts yield zero. The path that is not selected must pass its word through untouched, and stores must enable no lane outside the merged bytes.

// File: rtl/ua_merge_pkg.sv
package ua_merge_pkg;
  typedef enum logic [1:0] {
    OP_LD_HIGH = 2'd0,
    OP_LD_LOW  = 2'd1,
    OP_ST_HIGH = 2'd2,
    OP_ST_LOW  = 2'd3
  } ua_op_e;
endpackage

// File: rtl/ua_load_merge.sv
module ua_load_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              high_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int TOP = LANES - 1;

  logic [LANE_W-1:0] mem_l [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign mem_l[k] = mem_i[k*LANE_W +: LANE_W];

    always_comb begin
      int sum;
      logic [OFF_W-1:0] idx;
      sum = k + int'(offset_i);
      if (high_i) begin
        // mem lane k-(TOP-off), taken modulo the lane count
        idx = OFF_W'(sum + 1);
        data_o[k*LANE_W +: LANE_W] = (sum >= TOP) ? mem_l[idx]
                                                  : reg_i[k*LANE_W +: LANE_W];
      end else begin
        idx = OFF_W'(sum);
        data_o[k*LANE_W +: LANE_W] = (sum <= TOP) ? mem_l[idx]
                                                  : reg_i[k*LANE_W +: LANE_W];
      end
    end
  end

  always_comb begin
    if (!$isunknown({high_i, offset_i, mem_i})) begin
      if ((high_i && offset_i == OFF_W'(TOP)) || (!high_i && offset_i == '0))
        p_full_load_r6: assert (data_o == mem_i)
          else $error("full-word load does not return memory word");
    end
  end
endmodule

// File: rtl/ua_store_merge.sv
module ua_store_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              high_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] mem_i,
  input  logic [DATA_W-1:0] reg_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LANES-1:0]  en_o
);
  logic [LANE_W-1:0] reg_l [LANES];

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign reg_l[k] = reg_i[k*LANE_W +: LANE_W];

    always_comb begin
      int off;
      logic [OFF_W-1:0] idx;
      off = int'(offset_i);
      if (high_i) begin
        en_o[k] = (k <= off);
        idx     = OFF_W'(k + LANES - 1 - off);
      end else begin
        en_o[k] = (k >= off);
        idx     = OFF_W'(k + LANES - off);
      end
      data_o[k*LANE_W +: LANE_W] = en_o[k] ? reg_l[idx] : mem_i[k*LANE_W +: LANE_W];
    end
  end

  always_comb begin
    if (!$isunknown({high_i, offset_i})) begin
      if (high_i)
        p_high_en_count_r4: assert ($countones(en_o) == int'(offset_i) + 1)
          else $error("store-high enable count wrong");
      else
        p_low_en_count_r5: assert ($countones(en_o) == LANES - int'(offset_i))
          else $error("store-low enable count wrong");
    end
  end
endmodule

// File: rtl/ua_merge_top.sv
module ua_merge_top
  import ua_merge_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic [1:0]        op_i,
  input  logic [OFF_W-1:0]  offset_i,
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] reg_word_i,
  output logic [DATA_W-1:0] load_data_o,
  output logic [DATA_W-1:0] store_data_o,
  output logic [LANES-1:0]  byte_en_o
);
  ua_op_e op;
  logic is_store, is_high;
  logic [DATA_W-1:0] ld_data, st_data;
  logic [LANES-1:0]  st_en;

  assign op       = ua_op_e'(op_i);
  assign is_store = (op == OP_ST_HIGH) || (op == OP_ST_LOW);
  assign is_high  = (op == OP_LD_HIGH) || (op == OP_ST_HIGH);

  ua_load_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_load (
    .high_i   (is_high),
    .offset_i (offset_i),
    .mem_i    (mem_word_i),
    .reg_i    (reg_word_i),
    .data_o   (ld_data)
  );

  ua_store_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_store (
    .high_i   (is_high),
    .offset_i (offset_i),
    .mem_i    (mem_word_i),
    .reg_i    (reg_word_i),
    .data_o   (st_data),
    .en_o     (st_en)
  );

  assign load_data_o  = is_store ? ld_data_pass(reg_word_i) : ld_data;
  assign store_data_o = is_store ? st_data : mem_word_i;
  assign byte_en_o    = is_store ? st_en : '0;

  function automatic logic [DATA_W-1:0] ld_data_pass(input logic [DATA_W-1:0] v);
    return v;
  endfunction

  // lanes not enabled must keep the memory byte (R4, R5, R7)
  for (genvar k = 0; k < LANES; k++) begin : g_chk
    always_comb begin
      if (!$isunknown({op_i, offset_i, mem_word_i, reg_word_i}) && !byte_en_o[k])
        p_lane_keep_r7: assert (store_data_o[k*LANE_W +: LANE_W] ==
                                mem_word_i[k*LANE_W +: LANE_W])
          else $error("disabled lane %0d altered", k);
    end
  end
endmodule

// File: tb/ua_merge_top_test.sv
module ua_merge_top_test;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [1:0]  op;
  logic [1:0]  off;
  logic [31:0] mem, rg;
  logic [31:0] ld_o, st_o;
  logic [3:0]  en_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  ua_merge_top uut (
    .op_i         (op),
    .offset_i     (off),
    .mem_word_i   (mem),
    .reg_word_i   (rg),
    .load_data_o  (ld_o),
    .store_data_o (st_o),
    .byte_en_o    (en_o)
  );

  function automatic logic [63:0] lowmask(int n);
    return (64'd1 << n) - 64'd1;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s op=%0d off=%0d act=%h exp=%h", tag, op, off, act, exp);
    end
  endtask

  task automatic run_case(logic [1:0] o, logic [1:0] b, logic [31:0] m, logic [31:0] r);
    logic [31:0] e_ld, e_st;
    logic [3:0]  e_en;
    int s;
    @(posedge clk);
    op = o; off = b; mem = m; rg = r;
    e_ld = r; e_st = m; e_en = 4'h0;
    case (o)
      2'd0: begin s = 24 - 8*int'(b);
        e_ld = 32'({32'b0, m} << s) | (r & 32'(lowmask(s))); end
      2'd1: begin s = 8*int'(b);
        e_ld = (m >> s) | (r & 32'(lowmask(s) << (32 - s))); end
      2'd2: begin s = 24 - 8*int'(b);
        e_st = (r >> s) | (m & 32'(lowmask(s) << (32 - s)));
        e_en = 4'(lowmask(int'(b) + 1)); end
      default: begin s = 8*int'(b);
        e_st = 32'({32'b0, r} << s) | (m & 32'(lowmask(s)));
        e_en = 4'(4'hF << b); end
    endcase
    @(negedge clk);
    case (o)
      2'd0: begin
        chk("R1/R2 load-high data", ld_o, e_ld);
        chk("R7 load store-word passthrough", st_o, e_st);
      end
      2'd1: begin
        chk("R1/R3 load-low data", ld_o, e_ld);
        chk("R7 load store-word passthrough", st_o, e_st);
      end
      2'd2: begin
        chk("R1/R4 store-high data", st_o, e_st);
        chk("R7 store reg passthrough", ld_o, e_ld);
      end
      default: begin
        chk("R1/R5 store-low data", st_o, e_st);
        chk("R7 store reg passthrough", ld_o, e_ld);
      end
    endcase
    chk((o[1] ? "R4/R5 byte enables" : "R7 load enables zero"), {28'b0, en_o}, {28'b0, e_en});
    if ((o == 2'd0 && b == 2'd3) || (o == 2'd1 && b == 2'd0))
      chk("R6 full-word load", ld_o, m);
    if ((o == 2'd2 && b == 2'd3) || (o == 2'd3 && b == 2'd0)) begin
      chk("R6 full-word store data", st_o, r);
      chk("R6 full-word store enables", {28'b0, en_o}, 32'hF);
    end
  endtask

  logic [31:0] mems [6] = '{32'h11223344, 32'h00000000, 32'hFFFFFFFF,
                            32'hA5A5A5A5, 32'hDEADBEEF, 32'h80000001};
  logic [31:0] regs [6] = '{32'hAABBCCDD, 32'hFFFFFFFF, 32'h00000000,
                            32'h5A5A5A5A, 32'h01234567, 32'h7FFFFFFE};

  initial begin
    op = 2'd0; off = 2'd0; mem = '0; rg = '0;
    @(negedge clk);
    chk("R7 idle load-word zero", ld_o, 32'h0);
    chk("R7 idle store-word zero", st_o, 32'h0);
    chk("R7 idle enables zero", {28'b0, en_o}, 32'h0);
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 4; o++)
        for (int b = 0; b < 4; b++)
          run_case(2'(o), 2'(b), mems[p], regs[p]);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule